// File: doc/BRIEF.md
# Stop-Mode Wake-Up Delay Counter

This block holds a free-running system counter that doubles as the wake-up timer for a low-power stop state. It runs on a fast clock at four times the bus rate. When the processor issues its stop command, the counter is cleared to zero and the bus-clock enable drops. The counter then stays parked at zero until a wake source arrives. A wake source is a maskable interrupt, a debug break or the external reset pin.

A wake source starts the recovery count from zero. A short-recovery configuration input is captured at that moment and chooses the length of the wait: 32 fast-clock cycles when it is 1, or 4096 when it is 0. In the last cycle of the wait, a one-cycle done pulse is raised. From the next cycle the bus clock is enabled again and the counter goes on counting freely from where the recovery left it. The external reset pin never clears or disturbs the counter. Only the power-on reset initialises it.

Top module: `stoprec_ctrl`

## Requirements
- R1: While `por_n` is low, `count` is 0, `bus_clk_en` is 1, `recov_done` is 0 and `stop_active` is 0.
- R2: In normal running, `count` rises by exactly 1 on every fast-clock edge and wraps from all ones to 0.
- R3: A `stop_cmd` sampled high while running makes `count` 0, `bus_clk_en` 0 and `stop_active` 1 on the next edge.
- R4: While stopped and with no wake source high, `count` stays 0, `bus_clk_en` stays 0 and `recov_done` stays 0.
- R5: Any one of `irq_wake`, `brk_wake` or `ext_rst`, sampled high while stopped, starts recovery. On the edge that samples the wake, `count` stays 0. It then increments once per edge.
- R6: With `short_rec` = 1 at the wake edge, `recov_done` is high exactly in the cycle where `count` is 31. `bus_clk_en` returns to 1 on the following edge, 32 cycles after the wake edge.
- R7: With `short_rec` = 0 at the wake edge, `recov_done` is high exactly in the cycle where `count` is 4095. `bus_clk_en` returns to 1 on the following edge.
- R8: `short_rec` is sampled only at the wake edge. Changing it during recovery does not move the done cycle.
- R9: `recov_done` is a single-cycle pulse and is never high outside recovery.
- R10: A wake source that is high while recovery is running has no effect on `count` or on the done cycle.
- R11: `ext_rst` high while running leaves `count` incrementing by 1 and keeps `bus_clk_en` at 1.
- R12: After recovery ends, `count` keeps counting freely from the recovery's terminal value (32 or 4096, then onward).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_x4 | input | 1 | Fast clock at four times the bus rate |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | External reset pin level; wakes from stop, never touches the counter |
| stop_cmd | input | 1 | Stop command strobe from the processor |
| irq_wake | input | 1 | Interrupt wake request |
| brk_wake | input | 1 | Debug break wake request |
| short_rec | input | 1 | 1 selects the 32-cycle delay, 0 the 4096-cycle delay |
| count | output | CNT_W | Current counter value |
| bus_clk_en | output | 1 | Bus clock enable, low from stop entry to the end of recovery |
| recov_done | output | 1 | One-cycle pulse in the last recovery cycle |
| stop_active | output | 1 | High while stopped or recovering |

## Verification
The hardest situation to reach is a second wake source, or a change of `short_rec`, arriving in the middle of a recovery that is already running. That is the only place where the held delay selection and the ignore rule can show up.

The bench enters stop, wakes the block from each of the three sources with each delay setting, and follows the whole recovery cycle by cycle. During some of these runs it flips `short_rec` or pulses another wake source at chosen counts, and checks that the done pulse still lands on the terminal value that was captured at the wake edge.

The 16-bit wrap is reached by letting the counter run free for a full period.

// File: rtl/stoprec_pkg.sv
package stoprec_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STOP  = 2'd1,
        ST_RECOV = 2'd2
    } stoprec_state_e;

    typedef struct packed {
        stoprec_state_e state;
        logic           short_sel;
    } stoprec_ctl_t;

endpackage

// File: rtl/stoprec_term_sel.sv
module stoprec_term_sel #(
    parameter int CNT_W     = 16,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic             short_sel,
    output logic [CNT_W-1:0] term_m1
);
    localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_DLY - 1);
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_DLY - 1);

    generate
        if (LONG_DLY == SHORT_DLY) begin : g_single
            logic unused_sel;
            assign unused_sel = short_sel;
            assign term_m1    = LONG_M1;
        end else begin : g_dual
            assign term_m1 = short_sel ? SHORT_M1 : LONG_M1;
        end
    endgenerate

endmodule

// File: rtl/stoprec_counter.sv
module stoprec_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
        if (clr) begin
            cnt_d = '0;
        end else if (hold) begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: a clear request leaves the counter at zero
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (cnt_q == '0));

    // R2: with neither clear nor hold the counter advances by one
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!clr && !hold) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/stoprec_ctrl.sv
module stoprec_ctrl #(
    parameter int CNT_W     = 16,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic             clk_x4,
    input  logic             por_n,
    input  logic             ext_rst,
    input  logic             stop_cmd,
    input  logic             irq_wake,
    input  logic             brk_wake,
    input  logic             short_rec,
    output logic [CNT_W-1:0] count,
    output logic             bus_clk_en,
    output logic             recov_done,
    output logic             stop_active
);
    import stoprec_pkg::*;

    stoprec_ctl_t     ctl_d, ctl_q;
    logic             cnt_clr, cnt_hold, wake_any, at_term;
    logic [CNT_W-1:0] term_m1;
    logic [CNT_W-1:0] cnt_q;

    stoprec_term_sel #(
        .CNT_W    (CNT_W),
        .LONG_DLY (LONG_DLY),
        .SHORT_DLY(SHORT_DLY)
    ) u_term (
        .short_sel(ctl_q.short_sel),
        .term_m1  (term_m1)
    );

    stoprec_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk_x4),
        .por_n(por_n),
        .clr  (cnt_clr),
        .hold (cnt_hold),
        .cnt_q(cnt_q)
    );

    assign wake_any = irq_wake | brk_wake | ext_rst;
    assign at_term  = (ctl_q.state == ST_RECOV) && (cnt_q == term_m1);

    always_comb begin
        ctl_d    = ctl_q;
        cnt_clr  = 1'b0;
        cnt_hold = 1'b0;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (stop_cmd) begin
                    ctl_d.state = ST_STOP;
                    cnt_clr     = 1'b1;
                end
            end
            ST_STOP: begin
                cnt_hold = 1'b1;
                if (wake_any) begin
                    ctl_d.state     = ST_RECOV;
                    ctl_d.short_sel = short_rec;
                end
            end
            ST_RECOV: begin
                if (at_term) begin
                    ctl_d.state = ST_RUN;
                end
            end
            default: begin
                ctl_d.state = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_x4 or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '{state: ST_RUN, short_sel: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign count       = cnt_q;
    assign recov_done  = at_term;
    assign bus_clk_en  = (ctl_q.state == ST_RUN);
    assign stop_active = (ctl_q.state != ST_RUN);

    // R4: stopped without wake keeps the counter parked at zero
    assert_park_zero_R4: assert property (@(posedge clk_x4) disable iff (!por_n)
        (ctl_q.state == ST_STOP && !wake_any) |=> (count == '0 && !bus_clk_en));

    // R9: the done pulse lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk_x4) disable iff (!por_n)
        recov_done |=> !recov_done);

    // R6 and R7: the bus clock returns right after the done pulse
    assert_bus_back_R6: assert property (@(posedge clk_x4) disable iff (!por_n)
        recov_done |=> bus_clk_en);

    // R8: the delay choice is frozen while recovery runs
    assert_sel_frozen_R8: assert property (@(posedge clk_x4) disable iff (!por_n)
        (ctl_q.state == ST_RECOV) |=> (ctl_q.state != ST_RECOV || $stable(ctl_q.short_sel)));

    // R10: while recovering the counter advances regardless of wake inputs
    assert_recov_count_R10: assert property (@(posedge clk_x4) disable iff (!por_n)
        (ctl_q.state == ST_RECOV) |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: tb/stoprec_ctrl_test.sv
module stoprec_ctrl_test;

    localparam int W = 16;

    logic         clk_x4 = 1'b0;
    logic         por_n, ext_rst, stop_cmd, irq_wake, brk_wake, short_rec;
    logic [W-1:0] count;
    logic         bus_clk_en, recov_done, stop_active;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #4 clk_x4 = ~clk_x4;

    stoprec_ctrl #(.CNT_W(W), .LONG_DLY(4096), .SHORT_DLY(32)) uut (
        .clk_x4     (clk_x4),
        .por_n      (por_n),
        .ext_rst    (ext_rst),
        .stop_cmd   (stop_cmd),
        .irq_wake   (irq_wake),
        .brk_wake   (brk_wake),
        .short_rec  (short_rec),
        .count      (count),
        .bus_clk_en (bus_clk_en),
        .recov_done (recov_done),
        .stop_active(stop_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk_x4);
        @(negedge clk_x4);
    endtask

    task automatic enter_stop();
        stop_cmd = 1'b1;
        step();
        stop_cmd = 1'b0;
        chk(count == 0, "R3 count", int'(count), 0);
        chk(!bus_clk_en && stop_active, "R3 bus_clk_en", int'(bus_clk_en), 0);
        for (int i = 0; i < 4; i++) begin
            step();
            chk(count == 0 && !bus_clk_en && !recov_done, "R4 parked", int'(count), 0);
        end
    endtask

    // src: 0 irq, 1 brk, 2 ext_rst; flip_at/inject_at < 0 disables
    task automatic recover(input int src, input bit sr, input int flip_at, input int inject_at);
        int term;
        term = sr ? 32 : 4096;
        enter_stop();
        short_rec = sr;
        irq_wake  = (src == 0);
        brk_wake  = (src == 1);
        ext_rst   = (src == 2);
        step();
        irq_wake = 1'b0;
        brk_wake = 1'b0;
        ext_rst  = 1'b0;
        for (int k = 0; k < term; k++) begin
            if (count != W'(k) || bus_clk_en || (recov_done != (k == term - 1)))
                chk(1'b0, sr ? "R6 R5 recovery" : "R7 R5 recovery", int'(count), k);
            else
                checks++;
            irq_wake = (k == inject_at);
            brk_wake = (k == inject_at);
            if (k == flip_at) short_rec = ~sr;
            step();
        end
        irq_wake = 1'b0;
        brk_wake = 1'b0;
        chk(count == W'(term) && bus_clk_en && !recov_done && !stop_active,
            sr ? "R6 release" : "R7 release", int'(count), term);
        step();
        chk(count == W'(term + 1) && !recov_done, "R12 free run", int'(count), term + 1);
        chk(!recov_done, "R9 no done outside recovery", int'(recov_done), 0);
    endtask

    initial begin
        int c;
        por_n = 1'b0; ext_rst = 1'b0; stop_cmd = 1'b0;
        irq_wake = 1'b0; brk_wake = 1'b0; short_rec = 1'b0;
        step(); step();
        chk(count == 0, "R1 count", int'(count), 0);
        chk(bus_clk_en && !recov_done && !stop_active, "R1 flags", int'(bus_clk_en), 1);
        por_n = 1'b1;
        step();
        chk(count == 1, "R2 first step", int'(count), 1);
        for (int i = 0; i < 20; i++) begin
            c = int'(count);
            step();
            chk(int'(count) == c + 1, "R2 increment", int'(count), c + 1);
        end
        // R11: external reset while running
        c = int'(count);
        ext_rst = 1'b1;
        step();
        ext_rst = 1'b0;
        chk(int'(count) == c + 1 && bus_clk_en, "R11 ext_rst ignored", int'(count), c + 1);
        step();
        chk(int'(count) == c + 2 && !stop_active, "R11 ext_rst ignored", int'(count), c + 2);
        // R2 wrap
        while (count != {W{1'b1}}) step();
        step();
        chk(count == 0 && bus_clk_en, "R2 wrap", int'(count), 0);

        // R5/R6/R7: every source with both delays
        for (int s = 0; s < 3; s++) begin
            recover(s, 1'b1, -1, -1);
            recover(s, 1'b0, -1, -1);
        end
        // R8: flip the selection mid-recovery
        recover(0, 1'b1, 1, -1);
        recover(1, 1'b0, 10, -1);
        // R10: extra wake during recovery
        recover(2, 1'b1, -1, 5);
        recover(0, 1'b0, -1, 2000);
        // R12 back-to-back stop after recovery
        recover(1, 1'b1, 3, 20);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule